// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets a synchronous host read and write an external asynchronous static RAM that has a 16-bit data word split into two byte lanes and 17 address bits. The host presents a request with an address, a write flag, write data and a two-bit lane mask. A valid/ready handshake accepts the request and registers all of its fields. The controller then sequences the active-low chip select, write strobe, read strobe and the two lane strobes. It also drives an enable for the data bus driver that sits outside the block. When the access is over it returns a single-cycle completion pulse, which carries the read data for reads.

The memory's timing is given as nanosecond minimums. Each minimum becomes a cycle count by rounding up against the clock period parameter. The read window is ceil(55/period) cycles. The write strobe stays low for the largest of ceil(40/period), ceil(45/period), ceil(25/period) and ceil(55/period)-1 cycles, and one recovery cycle follows it. A write that follows a read waits ceil(20/period) cycles, at least one, so the memory can release the bus. After reset the controller stays quiet for a start-up count of cycles. With the default 10 ns period these counts are 6, 5 and 2; with a 20 ns period they are 3, 3 and 1. Every pin output comes from a flop.

Top module: `asram_ctrl`

## Requirements
- R1: After reset release, reqReady stays low for exactly STARTUP_CYCLES clock edges and then rises. Throughout reset and start-up, every memory strobe is high and the driver enable is low.
- R2: A read holds chip select and read strobe low, with the write strobe high, for exactly the read-window count of cycles. doneValid then pulses in the cycle after the strobes return high, and doneRdata holds the data sampled at that edge.
- R3: Mask bit 0 selects the lower lane, data bits 7..0, on sramLbN. Mask bit 1 selects the upper lane, bits 15..8, on sramUbN. A write changes only the selected lanes, and a write with mask 00 changes nothing.
- R4: For a read, lanes that are not selected return zero in doneRdata. For a write, the completion pulse carries zero.
- R5: A write holds the write strobe low for exactly the write-pulse count of cycles, with the read strobe high and the driver enabled. The write strobe then rises while chip select is still low and the driver is still on. The chip is deselected one cycle later.
- R6: When a write follows a read, at least one plus the release count of cycles pass between the read strobe rising and the driver enable rising.
- R7: reqReady is high only while the controller is idle. A request held valid while reqReady is low is neither accepted nor acted on. Each accepted request yields exactly one single-cycle doneValid.
- R8: Between accesses, chip select, both lane strobes, the write strobe and the read strobe are high, and the driver enable is low.
- R9: The write strobe and the read strobe are never low together, and the driver enable is never high while the read strobe is low.
- R10: sramAddr is stable while chip select is low, and every one of its 17 bits is carried from the request, including address 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select: bit 0 lower byte, bit 1 upper byte |
| doneValid | output | 1 | Single-cycle completion pulse |
| doneRdata | output | 16 | Read data (zero for writes and unselected lanes) |
| sramAddr | output | 17 | Memory address pins |
| sramDout | output | 16 | Data toward the bus driver |
| sramDoutEn | output | 1 | Bus driver enable |
| sramDin | input | 16 | Data from the bus |
| sramCeN | output | 1 | Chip select, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramOeN | output | 1 | Read strobe, active low |
| sramUbN | output | 1 | Upper lane strobe, active low |
| sramLbN | output | 1 | Lower lane strobe, active low |

## Verification
A wrong cycle counter shows up at the pins in the same access. The read window or write pulse comes out one or more cycles too long or too short. The memory model then hands back unsettled data, and that shows in the next completion pulse. A stale "last access was a read" flag moves the driver enable rise after a read, which is visible within a few cycles of the read ending. A lane-mask register that loads wrongly shows up both on the lane strobes during the access and as corrupted or unmasked bytes in doneRdata. A bad address register shows up as a read of the wrong word.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_WREC
  } asramState_e;

  // Pin levels for the next cycle plus datapath events, control -> datapath
  typedef struct packed {
    logic load;     // register the host request
    logic select;   // chip select active next cycle
    logic readOn;   // read strobe active next cycle
    logic writeOn;  // write strobe active next cycle
    logic drive;    // bus driver on next cycle
    logic capture;  // sample bus data at this edge
    logic finish;   // emit completion next cycle
  } asramStrobe_t;

  function automatic int ceilCycles(int ns, int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 5,
  parameter int TURN_CYC = 2,
  parameter int BOOT_CYC = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output asramStrobe_t strb
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] BOOT_LOAD = CNT_W'(BOOT_CYC - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  asramState_e      state, nxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             lastRead, lastNxt;

  always_comb begin
    nxt     = state;
    cntNxt  = cnt;
    lastNxt = lastRead;
    strb    = '0;
    case (state)
      ST_BOOT: begin
        if (cnt == '0) nxt = ST_IDLE;
        else           cntNxt = cnt - ONE;
      end
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          if (reqWrite) begin
            lastNxt = 1'b0;
            if (lastRead) begin
              nxt    = ST_TURN;
              cntNxt = TURN_LOAD;
            end else begin
              nxt    = ST_WRITE;
              cntNxt = WR_LOAD;
            end
          end else begin
            nxt    = ST_READ;
            cntNxt = RD_LOAD;
          end
        end
      end
      ST_TURN: begin
        if (cnt == '0) begin
          nxt    = ST_WRITE;
          cntNxt = WR_LOAD;
        end else begin
          cntNxt = cnt - ONE;
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          nxt          = ST_IDLE;
          strb.capture = 1'b1;
          strb.finish  = 1'b1;
          lastNxt      = 1'b1;
        end else begin
          cntNxt = cnt - ONE;
        end
      end
      ST_WRITE: begin
        if (cnt == '0) nxt = ST_WREC;
        else           cntNxt = cnt - ONE;
      end
      ST_WREC: begin
        nxt         = ST_IDLE;
        strb.finish = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
    strb.select  = (nxt == ST_READ) || (nxt == ST_WRITE) || (nxt == ST_WREC);
    strb.readOn  = (nxt == ST_READ);
    strb.writeOn = (nxt == ST_WRITE);
    strb.drive   = (nxt == ST_WRITE) || (nxt == ST_WREC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_BOOT;
      cnt      <= BOOT_LOAD;
      lastRead <= 1'b0;
    end else begin
      state    <= nxt;
      cnt      <= cntNxt;
      lastRead <= lastNxt;
    end
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/asram_ctrl_path.sv
`timescale 1ns/1ps
module asram_ctrl_path
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  asramStrobe_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  input  logic [DATA_W-1:0] sramDin,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramUbN,
  output logic              sramLbN,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0]  maskQ, maskNext, laneNextN, laneOnN;
  logic [DATA_W-1:0] laneData;

  assign maskNext = strb.load ? reqMask : maskQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneData[g*LANE_W +: LANE_W] = maskQ[g] ? sramDin[g*LANE_W +: LANE_W] : '0;
    assign laneNextN[g] = !(strb.select && maskNext[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr   <= '0;
      sramDout   <= '0;
      maskQ      <= '0;
      laneOnN    <= '1;
      sramCeN    <= 1'b1;
      sramWeN    <= 1'b1;
      sramOeN    <= 1'b1;
      sramDoutEn <= 1'b0;
      doneValid  <= 1'b0;
      doneRdata  <= '0;
    end else begin
      if (strb.load) begin
        sramAddr <= reqAddr;
        sramDout <= reqWdata;
        maskQ    <= reqMask;
      end
      laneOnN    <= laneNextN;
      sramCeN    <= !strb.select;
      sramWeN    <= !strb.writeOn;
      sramOeN    <= !strb.readOn;
      sramDoutEn <= strb.drive;
      doneValid  <= strb.finish;
      if (strb.finish) doneRdata <= strb.capture ? laneData : '0;
    end
  end

  assign sramLbN = laneOnN[0];
  assign sramUbN = laneOnN[1];

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 16,
  parameter int CLK_PERIOD_NS  = 10,
  parameter int T_READ_NS      = 55,
  parameter int T_WCYCLE_NS    = 55,
  parameter int T_WPULSE_NS    = 40,
  parameter int T_ADDR_WEND_NS = 45,
  parameter int T_DSETUP_NS    = 25,
  parameter int T_RELEASE_NS   = 20,
  parameter int STARTUP_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn,
  input  logic [DATA_W-1:0] sramDin,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramUbN,
  output logic              sramLbN
);

  localparam int RD_CYC   = ceilCycles(T_READ_NS, CLK_PERIOD_NS);
  localparam int WR_CYC   = max2(max2(ceilCycles(T_WPULSE_NS, CLK_PERIOD_NS),
                                      ceilCycles(T_ADDR_WEND_NS, CLK_PERIOD_NS)),
                                 max2(ceilCycles(T_DSETUP_NS, CLK_PERIOD_NS),
                                      ceilCycles(T_WCYCLE_NS, CLK_PERIOD_NS) - 1));
  localparam int TURN_CYC = ceilCycles(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int BOOT_CYC = max2(STARTUP_CYCLES, 1);
  localparam int CNT_MAX  = max2(max2(RD_CYC, WR_CYC), max2(TURN_CYC, BOOT_CYC));
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  asramStrobe_t strb;

  asram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .TURN_CYC(TURN_CYC),
    .BOOT_CYC(BOOT_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asram_ctrl_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqMask   (reqMask),
    .sramDin   (sramDin),
    .sramAddr  (sramAddr),
    .sramDout  (sramDout),
    .sramDoutEn(sramDoutEn),
    .sramCeN   (sramCeN),
    .sramWeN   (sramWeN),
    .sramOeN   (sramOeN),
    .sramUbN   (sramUbN),
    .sramLbN   (sramLbN),
    .doneValid (doneValid),
    .doneRdata (doneRdata)
  );

endmodule

// File: rtl/asram_ctrl_checks.sv
`timescale 1ns/1ps
module asram_ctrl_checks #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              doneValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramDoutEn,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramUbN,
  input logic              sramLbN
);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramWeN && !sramOeN));

  a_r9_no_drive_in_read: assert property (@(posedge clk) disable iff (!rstN)
    sramDoutEn |-> sramOeN);

  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sramCeN |-> (sramUbN && sramLbN && sramWeN && sramOeN && !sramDoutEn));

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  a_r5_write_ends_on_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (!sramCeN && sramDoutEn));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> sramCeN);

  a_r6_release_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |=> !sramDoutEn);

  a_r2_read_shape: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (sramWeN && !sramCeN));

endmodule

bind asram_ctrl asram_ctrl_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (.*);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int CLK_NS   = 20;
  localparam int STARTUP  = 20;
  localparam int RD_CYC   = (55 + CLK_NS - 1) / CLK_NS;  // 3
  localparam int WR_CYC   = (45 + CLK_NS - 1) / CLK_NS;  // 3 (largest term at 20 ns)
  localparam int TURN_CYC = (20 + CLK_NS - 1) / CLK_NS;  // 1

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        doneValid;
  logic [15:0] doneRdata;
  logic [16:0] sramAddr;
  logic [15:0] sramDout, sramDin = '0;
  logic        sramDoutEn, sramCeN, sramWeN, sramOeN, sramUbN, sramLbN;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_NS(CLK_NS), .STARTUP_CYCLES(STARTUP)) u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .doneValid(doneValid), .doneRdata(doneRdata), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDoutEn(sramDoutEn), .sramDin(sramDin),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramUbN(sramUbN), .sramLbN(sramLbN));

  int  nChecks = 0;
  int  nFails  = 0;
  bit  ended   = 1'b0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic endRun();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [int];
  realtime     tChg = 0;

  function automatic logic [15:0] memRd(int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(sramAddr, sramCeN, sramOeN, sramUbN, sramLbN) tChg = $realtime;

  always @(posedge sramWeN) begin
    if (rstN && !sramCeN) begin
      logic [15:0] w;
      w = memRd(int'(sramAddr));
      if (!sramLbN) w[7:0]  = sramDout[7:0];
      if (!sramUbN) w[15:8] = sramDout[15:8];
      mem[int'(sramAddr)] = w;
    end
  end

  // present bus data just before each rising edge; unsettled data reads DE, idle lanes EE
  always @(negedge clk) begin
    logic [15:0] w;
    bit settled;
    #(CLK_NS/2 - 1);
    w = memRd(int'(sramAddr));
    settled = ($realtime - tChg) >= 55.0;
    if (!sramCeN && !sramOeN && sramWeN) begin
      sramDin[7:0]  = !sramLbN ? (settled ? w[7:0]  : 8'hDE) : 8'hEE;
      sramDin[15:8] = !sramUbN ? (settled ? w[15:8] : 8'hDE) : 8'hEE;
    end else begin
      sramDin = 16'hEEEE;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] data;
    string       tag;
  } scoreItem_t;

  scoreItem_t  expQ[$];
  logic [15:0] shadow [int];
  logic [1:0]  curMask = 2'b00;

  function automatic logic [15:0] shadowRd(int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  task automatic issue(bit wr, int a, logic [15:0] d, logic [1:0] m, string tag);
    logic [15:0] w;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = 17'(a);
    reqWdata = d;
    reqMask  = m;
    curMask  = m;
    w = shadowRd(a);
    if (wr) begin
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      shadow[a] = w;
      expQ.push_back('{16'h0000, tag});
    end else begin
      expQ.push_back('{{m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00}, tag});
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && doneValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 done without request", 32'(doneRdata), 32'h0);
      end else begin
        scoreItem_t it;
        it = expQ.pop_front();
        check(doneRdata == it.data, it.tag, 32'(doneRdata), 32'(it.data));
      end
    end
  end

  // ---------------- pin timing monitor ----------------
  int   rdRun = 0, wrRun = 0, gap = 0;
  bit   prevRead = 1'b0;
  logic doePrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!sramCeN && !sramOeN) begin
        if (rdRun == 0)
          check({!sramUbN, !sramLbN} == curMask, "R3 lane strobes on read",
                32'({!sramUbN, !sramLbN}), 32'(curMask));
        rdRun++;
      end else if (rdRun != 0) begin
        check(rdRun == RD_CYC, "R2 read window length", 32'(rdRun), 32'(RD_CYC));
        rdRun = 0;
      end
      if (!sramWeN) begin
        wrRun++;
      end else if (wrRun != 0) begin
        check(wrRun == WR_CYC, "R5 write pulse length", 32'(wrRun), 32'(WR_CYC));
        check(!sramCeN && sramDoutEn, "R5 write ends on write strobe",
              32'({sramCeN, sramDoutEn}), 32'b01);
        wrRun = 0;
      end
      if (!sramOeN) begin
        gap = 0;
        prevRead = 1'b1;
      end else if (!sramDoutEn) begin
        gap++;
      end
      if (sramDoutEn && !doePrev) begin
        if (prevRead)
          check(gap >= 1 + TURN_CYC, "R6 bus release before drive",
                32'(gap), 32'(1 + TURN_CYC));
        prevRead = 1'b0;
      end
      doePrev = sramDoutEn;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_NS * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    endRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sramCeN && sramWeN && sramOeN && sramUbN && sramLbN && !sramDoutEn,
          "R1 pins quiet in reset",
          32'({sramCeN, sramWeN, sramOeN, sramUbN, sramLbN, sramDoutEn}), 32'b111110);
    check(!reqReady, "R1 not ready in reset", 32'(reqReady), 32'h0);
    rstN = 1'b1;
    n = 0;
    while (!reqReady && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == STARTUP, "R1 start-up length", 32'(n), 32'(STARTUP));

    // R2 plain reads and writes
    issue(1, 3, 16'h1111, 2'b11, "R2 write full word");
    issue(1, 4, 16'h2222, 2'b11, "R2 write full word");
    issue(0, 3, 16'h0, 2'b11, "R2 read back word 3");
    issue(0, 4, 16'h0, 2'b11, "R2 read back word 4");

    // R3 lane writes, R4 lane reads
    issue(1, 3, 16'hABCD, 2'b01, "R3 lower lane write");
    issue(0, 3, 16'h0, 2'b11, "R3 only lower lane changed");
    issue(1, 3, 16'h7700, 2'b10, "R3 upper lane write");
    issue(0, 3, 16'h0, 2'b11, "R3 only upper lane changed");
    issue(0, 3, 16'h0, 2'b01, "R4 upper lane zeroed");
    issue(0, 3, 16'h0, 2'b10, "R4 lower lane zeroed");
    issue(0, 3, 16'h0, 2'b00, "R4 no lane read gives zero");
    issue(1, 3, 16'hFFFF, 2'b00, "R3 empty mask write");
    issue(0, 3, 16'h0, 2'b11, "R3 empty mask changed nothing");

    // R10 address extremes
    issue(1, 17'h1FFFF, 16'hC3A5, 2'b11, "R10 write top address");
    issue(1, 0, 16'h5A3C, 2'b11, "R10 write address zero");
    issue(0, 17'h1FFFF, 16'h0, 2'b11, "R10 read top address");
    issue(0, 0, 16'h0, 2'b11, "R10 read address zero");

    // R6 read immediately followed by writes, mixed patterns
    for (int i = 0; i < 6; i++) begin
      issue(0, i * 17'h2A51, 16'h0, 2'b11, "R6 read before write");
      issue(1, i * 17'h2A51, 16'(16'h1357 * (i + 1)), 2'(i + 1), "R6 write after read");
      issue(0, i * 17'h2A51, 16'h0, 2'b11, "R6 data after turnaround");
    end

    // R7 requests while busy are ignored
    issue(1, 10, 16'h5555, 2'b11, "R7 write before busy requests");
    while (!reqReady) begin
      reqValid = 1'b1;
      reqWrite = 1'b1;
      reqAddr  = 17'd11;
      reqWdata = 16'h9999;
      reqMask  = 2'b11;
      @(negedge clk);
    end
    reqValid = 1'b0;
    issue(0, 11, 16'h0, 2'b11, "R7 busy request not written");
    issue(0, 10, 16'h0, 2'b11, "R7 accepted write intact");

    n = 0;
    while (expQ.size() != 0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R7 one completion per request", 32'(expQ.size()), 32'h0);
    check(sramCeN && !sramDoutEn, "R8 deselected when idle",
          32'({sramCeN, sramDoutEn}), 32'b10);
    endRun();
  end

endmodule